// File: doc/BRIEF.md
# Serial Word EEPROM Emulator

This block stands in for a small serial EEPROM of 16-bit words inside a larger chip. The block runs from a fast system clock and samples the serial pins as ordinary inputs. Those pins are an active-low select, a serial clock, a data input and a data output with a separate enable that models high impedance. The block also takes a write-control input and drives a ready/busy flag. The flag is low while a write is in progress.

Each transaction is a frame of up to 32 serial clocks. It starts with a fixed start pattern and a 4-bit opcode, then carries an 8-bit address and, for writes, a 16-bit data word. Four commands are decoded: read, write, write-enable and write-disable. An accepted write starts a self-timed programming interval of a parameterised number of system clocks. The word is committed to the internal register array only when that interval ends. Write-control can block a write or abort one in progress. After a write, the host can poll the ready/busy state on the data output by lowering select while the serial clock is low.

Top module: `sermem_emul`

## Requirements
- R1: After reset, ready/busy is high, the data output enable is low, the write-enable latch is clear and every word of the array reads as zero.
- R2: The first serial bit of a frame is bit 0. Bits 0 to 3 must be 1,0,1,0 and bits 4 to 7 form the opcode, sent leftmost first: read 1000, write 0100, write-enable 0011, write-disable 0000. Bits 8 to 15 are the address, least significant bit first. Bits 16 to 31 are the write data, least significant bit first. A frame whose first eight bits are not a valid start pattern plus opcode is ignored until select goes high.
- R3: For a read, the data output is enabled from the falling serial edge that ends clock 16. Data bits D0 to D15 appear on that falling edge and the 15 falling edges after it. The enable stays high until select rises.
- R4: Write-enable sets the latch and write-disable clears it, both on the 16th rising serial edge. A write frame received while the latch is clear is ignored: ready/busy stays high and the addressed word is unchanged.
- R5: An accepted write drops ready/busy shortly after the 32nd rising serial edge. Ready/busy stays low for exactly WR_CYCLES system clocks, then returns high with the new word stored.
- R6: Write-control high at any time during the entry of a write frame blocks that write. Read, write-enable and write-disable behave the same whatever the level of write-control.
- R7: Write-control high during the busy interval ends it within a few system clocks, even with select high. The addressed word keeps its old value.
- R8: After an accepted write, a falling select while the serial clock is low enables the data output. The output then shows ready/busy: 0 while busy, 1 once ready. Select high turns the enable off.
- R9: While busy, no new frame is decoded. Serial clocks sent then leave the output showing status and do not start a read.
- R10: Select high during a read cancels it and turns the output enable off. The next frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| wr_ctl_i | input | 1 | Write control; high blocks or aborts writes |
| sdo_o | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe_o | output | 1 | Data output enable; low models high impedance |
| rdy_o | output | 1 | Ready/busy; low while a write is programming |

## Verification
The hardest state to reach from the pins is status polling in the middle of a programming interval. Reaching it needs an accepted write, then a select pulse timed against a low serial clock, then a full read header, all before the interval ends. The bench therefore uses a programming interval longer than a frame. It polls at once after the write and sends a read header while busy, confirming the output still shows busy status. It then waits out the interval and sees the status flip to ready. A second awkward case is an abort while deselected: the bench raises write-control mid-interval with select high, then reads the word back to confirm it kept its old value.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam int FRAME_LEN = 32;
  localparam int HDR_LEN   = 8;
  localparam int CMD_LEN   = 16;
  localparam int WORD_W    = 16;
  localparam int AFLD_W    = 8;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  localparam logic [3:0] START_PAT = 4'b1010;
  localparam logic [3:0] OP_RD     = 4'b1000;
  localparam logic [3:0] OP_WR     = 4'b0100;
  localparam logic [3:0] OP_WEN    = 4'b0011;
  localparam logic [3:0] OP_WDIS   = 4'b0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_SKIP, ST_POST
  } dec_st_e;
endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], din_i[g]};
    end
    assign lvl_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int DEPTH = 256,
  parameter int WORD_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sermem_wtimer.sv
module sermem_wtimer #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int WR_CYCLES = 1000,
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam logic [TW-1:0] LAST = TW'(WR_CYCLES - 1);

  logic          busy_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      waddr_o <= addr_i;
      wdata_o <= data_i;
    end else if (busy_q) begin
      if (abort_i || cnt_q == LAST) busy_q <= 1'b0;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q && !abort_i && (cnt_q == LAST);

  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && abort_i) |=> !busy_q);
  // R5
  commit_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !busy_o);
endmodule

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  input  logic              wc_s_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              wr_start_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  dec_st_e              st_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-1:0] frame_q, frame_nx;
  logic                 cs_q, sck_q;
  logic                 wen_q, wc_seen_q, rd_on_q, poll_q, dout_q;
  logic [WORD_W-1:0]    rd_sh_q;
  logic [4:0]           obit_q;
  logic [3:0]           start_nx, op_nx;
  logic                 sck_rise, sck_fall, cs_fall, hdr_ok, wr_ok;

  assign sck_rise = sck_s_i && !sck_q;
  assign sck_fall = !sck_s_i && sck_q;
  assign cs_fall  = !cs_s_i && cs_q;

  always_comb begin
    frame_nx = frame_q;
    frame_nx[cnt_q] = sdi_s_i;
  end

  assign start_nx  = {frame_nx[0], frame_nx[1], frame_nx[2], frame_nx[3]};
  assign op_nx     = {frame_nx[4], frame_nx[5], frame_nx[6], frame_nx[7]};
  assign hdr_ok    = (start_nx == START_PAT) &&
                     (op_nx == OP_RD || op_nx == OP_WR || op_nx == OP_WEN || op_nx == OP_WDIS);
  assign rd_addr_o = frame_nx[HDR_LEN +: ADDR_W];
  assign wr_addr_o = frame_nx[HDR_LEN +: ADDR_W];
  assign wr_data_o = frame_nx[CMD_LEN +: WORD_W];
  assign wr_ok     = wen_q && !wc_seen_q && !wc_s_i;
  assign wr_start_o = (st_q == ST_CMD) && !cs_s_i && sck_rise &&
                      (cnt_q == CNT_W'(FRAME_LEN - 1)) && (op_nx == OP_WR) && wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      frame_q   <= '0;
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      wen_q     <= 1'b0;
      wc_seen_q <= 1'b0;
      rd_on_q   <= 1'b0;
      poll_q    <= 1'b0;
      dout_q    <= 1'b0;
      rd_sh_q   <= '0;
      obit_q    <= '0;
    end else begin
      cs_q  <= cs_s_i;
      sck_q <= sck_s_i;
      if (cs_s_i) begin
        poll_q  <= 1'b0;
        rd_on_q <= 1'b0;
        if (!(st_q == ST_POST && busy_i)) st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (!busy_i) begin
            st_q      <= ST_CMD;
            cnt_q     <= '0;
            wc_seen_q <= wc_s_i;
          end
          ST_CMD: begin
            if (wc_s_i) wc_seen_q <= 1'b1;
            if (sck_rise) begin
              frame_q <= frame_nx;
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(HDR_LEN - 1) && !hdr_ok) st_q <= ST_SKIP;
              if (cnt_q == CNT_W'(CMD_LEN - 1)) begin
                if (op_nx == OP_RD) begin
                  rd_sh_q <= rd_data_i;
                  obit_q  <= '0;
                  st_q    <= ST_READ;
                end else if (op_nx == OP_WEN) begin
                  wen_q <= 1'b1;
                  st_q  <= ST_SKIP;
                end else if (op_nx == OP_WDIS) begin
                  wen_q <= 1'b0;
                  st_q  <= ST_SKIP;
                end
              end
              if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
                poll_q <= 1'b0;
                st_q   <= wr_ok ? ST_POST : ST_SKIP;
              end
            end
          end
          ST_READ: if (sck_fall && obit_q != 5'(WORD_W)) begin
            rd_on_q <= 1'b1;
            dout_q  <= rd_sh_q[0];
            rd_sh_q <= rd_sh_q >> 1;
            obit_q  <= obit_q + 1'b1;
          end
          ST_POST: if (cs_fall && !sck_s_i) poll_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign sdo_oe_o = (st_q == ST_READ && rd_on_q) || (st_q == ST_POST && poll_q);
  assign sdo_o    = sdo_oe_o && ((st_q == ST_POST) ? !busy_i : dout_q);

  // R9
  no_cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD) |-> !busy_i);
  // R8
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && $past(cs_s_i)) |-> !sdo_oe_o);
  // R3
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ && sdo_oe_o && !cs_s_i) |=> sdo_oe_o);
endmodule

// File: rtl/sermem_emul.sv
module sermem_emul
  import sermem_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WR_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic wr_ctl_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic rdy_o
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [3:0]        pins_s;
  logic              busy, wr_start, mem_we;
  logic [ADDR_W-1:0] rd_addr, wr_addr, mem_waddr;
  logic [WORD_W-1:0] rd_data, wr_data, mem_wdata;

  sermem_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) i_sync (
    .clk_i, .rst_ni,
    .din_i ({wr_ctl_i, sdi_i, sck_i, cs_ni}),
    .lvl_o (pins_s)
  );

  sermem_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i, .rst_ni,
    .cs_s_i    (pins_s[0]),
    .sck_s_i   (pins_s[1]),
    .sdi_s_i   (pins_s[2]),
    .wc_s_i    (pins_s[3]),
    .busy_i    (busy),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .wr_start_o(wr_start),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o,
    .sdo_oe_o
  );

  sermem_wtimer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WR_CYCLES(WR_CYCLES)) i_wtimer (
    .clk_i, .rst_ni,
    .start_i (wr_start),
    .addr_i  (wr_addr),
    .data_i  (wr_data),
    .abort_i (pins_s[3]),
    .busy_o  (busy),
    .we_o    (mem_we),
    .waddr_o (mem_waddr),
    .wdata_o (mem_wdata)
  );

  sermem_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_array (
    .clk_i, .rst_ni,
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign rdy_o = !busy;
endmodule

// File: tb/test_sermem_emul.sv
`timescale 1ns/1ps
module test_sermem_emul;
  localparam int WRC  = 600;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wc = 1'b0;
  logic sdo, sdo_oe, rdy;

  int nchk = 0, nfail = 0;
  logic [15:0] exp_q[$];
  logic rd_active = 1'b0;
  int lowcnt = 0;
  logic rdy_d = 1'b1;

  always #2 clk = ~clk;

  sermem_emul #(.DEPTH(256), .WR_CYCLES(WRC)) i_sermem_emul (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .wr_ctl_i(wc), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rdy_o(rdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // length of the last low run of ready/busy
  always @(negedge clk) begin
    if (!rdy) lowcnt <= rdy_d ? 1 : lowcnt + 1;
    rdy_d <= rdy;
  end

  // monitor: collect read bits on falling serial edges, compare with scoreboard
  initial begin
    logic [15:0] got;
    int nb;
    nb = 0;
    got = '0;
    forever begin
      @(negedge sck);
      if (rd_active) begin
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b1, "R3 oe during read", 32'(sdo_oe), 1);
        got[nb] = sdo;
        nb++;
        if (nb == 16) begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R3 read word", 32'(got), 32'(e));
          nb = 0;
        end
      end
    end
  end

  function automatic logic [31:0] mkframe(input logic [3:0] st, input logic [3:0] op,
                                          input logic [7:0] a, input logic [15:0] d);
    logic [31:0] f;
    for (int i = 0; i < 4; i++) begin
      f[i]   = st[3-i];
      f[4+i] = op[3-i];
    end
    for (int i = 0; i < 8; i++)  f[8+i]  = a[i];
    for (int i = 0; i < 16; i++) f[16+i] = d[i];
    return f;
  endfunction

  task automatic pulse(input logic b);
    @(negedge clk);
    sck = 1'b0;
    sdi = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic fr_begin();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic fr_end();
    @(negedge clk);
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] f, input int n);
    for (int i = 0; i < n; i++) pulse(f[i]);
  endtask

  task automatic cmd16(input logic [3:0] op);
    fr_begin();
    send(mkframe(4'b1010, op, 8'h00, 16'h0), 16);
    fr_end();
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] d);
    fr_begin();
    send(mkframe(4'b1010, 4'b0100, a, d), 32);
    fr_end();
  endtask

  task automatic read_word(input logic [7:0] a, input logic [15:0] e);
    logic [31:0] f;
    f = mkframe(4'b1010, 4'b1000, a, 16'h0);
    exp_q.push_back(e);
    fr_begin();
    send(f, 16);
    rd_active = 1'b1;
    send(f, 16);
    rd_active = 1'b0;
    fr_end();
  endtask

  task automatic wait_rdy();
    int t;
    t = 0;
    while (!rdy && t < 5 * WRC) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(rdy == 1'b1, "R1 rdy after reset", 32'(rdy), 1);
    chk(sdo_oe == 1'b0, "R1 oe after reset", 32'(sdo_oe), 0);

    // R4 write with latch clear is ignored; R1 latch clear and array zero
    write_word(8'h05, 16'hFFFF);
    chk(rdy == 1'b1, "R4 R1 write ignored, rdy", 32'(rdy), 1);
    read_word(8'h05, 16'h0000);

    // R6 write-enable works with wc high
    wc = 1'b1;
    cmd16(4'b0011);
    wc = 1'b0;
    repeat (4) @(negedge clk);

    // R5 accepted write: busy length and commit
    write_word(8'h05, 16'hA5C3);
    chk(rdy == 1'b0, "R5 busy after write", 32'(rdy), 0);
    wait_rdy();
    chk(lowcnt == WRC, "R5 busy length", 32'(lowcnt), 32'(WRC));
    read_word(8'h05, 16'hA5C3);

    write_word(8'hFF, 16'h1234);
    wait_rdy();
    // R6 read with wc high
    wc = 1'b1;
    read_word(8'hFF, 16'h1234);
    wc = 1'b0;
    read_word(8'h05, 16'hA5C3);

    // R6 wc high during entry blocks the write
    fr_begin();
    send(mkframe(4'b1010, 4'b0100, 8'h05, 16'h0F0F), 10);
    wc = 1'b1;
    send(mkframe(4'b1010, 4'b0100, 8'h05, 16'h0F0F) >> 10, 4);
    wc = 1'b0;
    send(mkframe(4'b1010, 4'b0100, 8'h05, 16'h0F0F) >> 14, 18);
    fr_end();
    chk(rdy == 1'b1, "R6 blocked write rdy", 32'(rdy), 1);
    read_word(8'h05, 16'hA5C3);

    // R7 abort during busy with select high
    write_word(8'h05, 16'h5555);
    repeat (20) @(negedge clk);
    wc = 1'b1;
    repeat (6) @(negedge clk);
    chk(rdy == 1'b1, "R7 abort rdy", 32'(rdy), 1);
    wc = 1'b0;
    repeat (4) @(negedge clk);
    read_word(8'h05, 16'hA5C3);

    // R8 R9 status polling during busy
    write_word(8'h22, 16'hBEEF);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b1, "R8 poll oe", 32'(sdo_oe), 1);
    chk(sdo == 1'b0, "R8 poll busy", 32'(sdo), 0);
    send(mkframe(4'b1010, 4'b1000, 8'h22, 16'h0), 20);
    chk(rdy == 1'b0, "R9 still busy", 32'(rdy), 0);
    chk(sdo_oe == 1'b1 && sdo == 1'b0, "R9 status not data", 32'({sdo_oe, sdo}), 32'h2);
    @(negedge clk);
    sck = 1'b0;
    wait_rdy();
    chk(sdo == 1'b1, "R8 poll ready", 32'(sdo), 1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b0, "R8 oe off on deselect", 32'(sdo_oe), 0);
    repeat (2 * HALF) @(negedge clk);
    read_word(8'h22, 16'hBEEF);

    // R10 cancel a read
    fr_begin();
    send(mkframe(4'b1010, 4'b1000, 8'hFF, 16'h0), 20);
    chk(sdo_oe == 1'b1, "R10 oe before cancel", 32'(sdo_oe), 1);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b0, "R10 oe after cancel", 32'(sdo_oe), 0);
    sck = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    read_word(8'h05, 16'hA5C3);

    // R2 bad start pattern ignored even with latch set
    fr_begin();
    send(mkframe(4'b1110, 4'b0100, 8'h05, 16'h1111), 32);
    fr_end();
    chk(rdy == 1'b1, "R2 bad start ignored", 32'(rdy), 1);
    read_word(8'h05, 16'hA5C3);

    // R4 write-disable then write ignored
    cmd16(4'b0000);
    write_word(8'h05, 16'h7777);
    chk(rdy == 1'b1, "R4 disabled write rdy", 32'(rdy), 1);
    read_word(8'h05, 16'hA5C3);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule